// File: doc/BRIEF.md
# Composite Clock Slice Generator

This block turns one of several reference tick streams into a slower, gated tick stream, all inside a single fast system clock domain. Each reference is given as a one-cycle enable pulse on `src_tick`. A source multiplexer picks one of the references. Two programmable dividers in cascade then reduce the pulse rate: a coarse pre-divider first, then a finer post-divider. A gate at the end can silence the result. The block produces `slice_tick`, the divided enable pulse, and `slice_clk`, a level that flips on every output pulse. Downstream logic can use `slice_clk` as a slow square-wave reference.

All settings live in one 32-bit control word. Software can overwrite the whole word through a single-cycle write port. A second write port changes only the two divider fields, in the same cycle, and keeps the source and gate settings as they are. Both divider fields hold the ratio minus one. When the source or either ratio changes, both divide counters restart, so the new ratio begins on a clean boundary.

Top module: `clk_slice_gen`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the control word to zero: source 0, both ratios 1, gate off. It also clears both divide counters, `slice_tick` and `slice_clk`.
- R2: The control word layout is: gate enable at bit 28, source select at bits 26:24, pre-divide field at bits 18:16, post-divide field at bits 5:0. All other bits read as zero and ignore writes. A full write of 0xFFFFFFFF therefore reads back as 0x1707003F on the next cycle.
- R3: Only `src_tick[sel]` advances the dividers. Pulses on unselected sources have no effect on the output.
- R4: A pre field value p and a post field value q give one output pulse for every (p+1)*(q+1) selected input pulses. With both fields at zero, every input pulse passes through.
- R5: An output pulse appears on `slice_tick` in the clock cycle after the input pulse that completes the count.
- R6: A divider write (`div_wr`) loads `div_pre` into bits 18:16 and `div_post` into bits 5:0 in one cycle and leaves every other bit unchanged. If `reg_wr` is asserted in the same cycle, the full write wins.
- R7: A write that changes the source, pre or post field clears both divide counters and `slice_tick`/`slice_clk` at that edge. Counting then starts from zero.
- R8: While the gate bit is clear, `slice_tick` and `slice_clk` stay low and both counters are held at zero.
- R9: `slice_clk` inverts on each output pulse, so after a restart it equals the parity of the pulses emitted since then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | NUM_SRC | One-cycle enable pulses, one per reference source |
| reg_wr | input | 1 | Full control-word write strobe |
| reg_wdata | input | 32 | Full control-word write data |
| div_wr | input | 1 | Divider-only write strobe |
| div_pre | input | 3 | New pre-divide field (ratio minus one) |
| div_post | input | 6 | New post-divide field (ratio minus one) |
| reg_rdata | output | 32 | Current control word |
| slice_tick | output | 1 | Divided, gated enable pulse |
| slice_clk | output | 1 | Level that toggles on each output pulse |

## Verification
A counter that has the wrong value shows up as a wrong count of output pulses for a ratio. The error is visible within one full output period, at most 512 selected input pulses. A missed restart or gate hold shows up the same way, and it also leaves `slice_clk` with the wrong parity after the next burst. A wrong mux index shows up at once as a doubled or zero pulse rate, because the unselected sources tick at twice the rate of the selected one. Register layout faults appear on `reg_rdata` one cycle after the write.

// File: rtl/csg_pkg.sv
// Package: control-word layout and helpers for the clock slice generator.
// Assumes a 32-bit control word whose field positions are fixed by software.
package csg_pkg;
    localparam int WORD_W   = 32;
    localparam int SEL_W    = 3;
    localparam int PRE_W    = 3;
    localparam int POST_W   = 6;
    localparam int MAX_SRC  = 1 << SEL_W;

    localparam int GATE_BIT = 28;
    localparam int SEL_LSB  = 24;
    localparam int PRE_LSB  = 16;
    localparam int POST_LSB = 0;

    typedef struct packed {
        logic              gate;
        logic [SEL_W-1:0]  sel;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } csg_cfg_t;

    // Packs a configuration into its control-word image.
    function automatic logic [WORD_W-1:0] cfg_to_word(csg_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[GATE_BIT]             = c.gate;
        w[SEL_LSB +: SEL_W]     = c.sel;
        w[PRE_LSB +: PRE_W]     = c.pre;
        w[POST_LSB +: POST_W]   = c.post;
        return w;
    endfunction

    // Extracts the configuration fields from a control-word image.
    function automatic csg_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
        csg_cfg_t c;
        c.gate = w[GATE_BIT];
        c.sel  = w[SEL_LSB +: SEL_W];
        c.pre  = w[PRE_LSB +: PRE_W];
        c.post = w[POST_LSB +: POST_W];
        return c;
    endfunction

    localparam csg_cfg_t ALL_ONES_CFG = '{gate: 1'b1, sel: '1, pre: '1, post: '1};
    localparam logic [WORD_W-1:0] FIELD_MASK = cfg_to_word(ALL_ONES_CFG);
endpackage

// File: rtl/csg_ctrl_reg.sv
// Module: control word holder. It applies full writes or divider-only writes.
// A full write has priority. The restart output pulses in the cycle of a write
// that changes the source or either ratio.
// Assumes both write strobes are single-cycle and synchronous to clk.
module csg_ctrl_reg
    import csg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              div_wr,
    input  logic [PRE_W-1:0]  div_pre,
    input  logic [POST_W-1:0] div_post,
    output csg_cfg_t          cfg,
    output logic [WORD_W-1:0] rdata,
    output logic              restart
);
    csg_cfg_t cur_q;
    csg_cfg_t nxt;

    // Next configuration: a full write wins over a divider-only write.
    always_comb begin
        nxt = cur_q;
        if (reg_wr) begin
            nxt = word_to_cfg(reg_wdata);
        end else if (div_wr) begin
            nxt.pre  = div_pre;
            nxt.post = div_post;
        end
    end

    // Restart strobe: a rate-defining field is about to change.
    always_comb begin
        restart = (nxt.sel != cur_q.sel) || (nxt.pre != cur_q.pre) ||
                  (nxt.post != cur_q.post);
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt;
    end

    assign cfg   = cur_q;
    assign rdata = cfg_to_word(cur_q);

    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> rdata == ($past(reg_wdata) & FIELD_MASK));

    p_div_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && !reg_wr) |=>
            (rdata[PRE_LSB +: PRE_W] == $past(div_pre)) &&
            (rdata[POST_LSB +: POST_W] == $past(div_post)) &&
            (rdata[WORD_W-1:PRE_LSB+PRE_W] == $past(rdata[WORD_W-1:PRE_LSB+PRE_W])));
endmodule

// File: rtl/csg_div_stage.sv
// Module: one divide stage with a minus-one limit. It emits one pulse for
// every limit+1 input pulses. The output is combinational on the completing
// input pulse. Clear restarts the count and suppresses output that cycle.
// Assumes limit changes only in a cycle where clear is also asserted.
module csg_div_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         in_tick,
    input  logic [W-1:0] limit,
    output logic         out_tick
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end   = (cnt_q == limit);
    assign out_tick = in_tick && at_end && !clear;

    // Input pulse counter with wrap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (in_tick)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
endmodule

// File: rtl/clk_slice_gen.sv
// Module: top of the clock slice generator. It does source select, then
// pre-divide, then post-divide, then the gate. The output pulse and the
// toggling level are registered.
// Assumes every src_tick bit is a one-cycle enable pulse in the clk domain.
module clk_slice_gen
    import csg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    input  logic               div_wr,
    input  logic [2:0]         div_pre,
    input  logic [5:0]         div_post,
    output logic [31:0]        reg_rdata,
    output logic               slice_tick,
    output logic               slice_clk
);
    csg_cfg_t           cfg;
    logic               restart;
    logic               clear;
    logic [MAX_SRC-1:0] src_pad;
    logic               sel_tick;
    logic               pre_tick;
    logic               post_tick;
    logic               tick_q;
    logic               lvl_q;

    csg_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .div_wr    (div_wr),
        .div_pre   (div_pre),
        .div_post  (div_post),
        .cfg       (cfg),
        .rdata     (reg_rdata),
        .restart   (restart)
    );

    // Pad the source vector to the full select range; missing sources never tick.
    for (genvar i = 0; i < MAX_SRC; i++) begin : g_src
        if (i < NUM_SRC) begin : g_live
            assign src_pad[i] = src_tick[i];
        end else begin : g_dead
            assign src_pad[i] = 1'b0;
        end
    end

    assign sel_tick = src_pad[cfg.sel];
    assign clear    = restart || !cfg.gate;

    csg_div_stage #(.W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .in_tick  (sel_tick),
        .limit    (cfg.pre),
        .out_tick (pre_tick)
    );

    csg_div_stage #(.W(POST_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .in_tick  (pre_tick),
        .limit    (cfg.post),
        .out_tick (post_tick)
    );

    // Output pulse register and toggling level, both cleared by restart or gate-off.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tick_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            tick_q <= post_tick;
            if (post_tick) lvl_q <= !lvl_q;
        end
    end

    assign slice_tick = tick_q;
    assign slice_clk  = lvl_q;

    p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.gate |=> !slice_tick && !slice_clk);

    p_src_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slice_tick |-> $past(sel_tick));

    p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        post_tick |=> slice_tick && (slice_clk != $past(slice_clk)));
endmodule

// File: tb/clk_slice_gen_test.sv
// Bench: sweeps pre/post ratios and source selects. Expected pulse counts
// and levels are computed arithmetically.
module clk_slice_gen_test;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_tick = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic          div_wr = 1'b0;
    logic [2:0]    div_pre = '0;
    logic [5:0]    div_post = '0;
    logic [31:0]   reg_rdata;
    logic          slice_tick;
    logic          slice_clk;

    int n_checks = 0;
    int n_errors = 0;
    int pulses = 0;
    bit finished = 0;

    clk_slice_gen #(.NUM_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .div_wr(div_wr), .div_pre(div_pre), .div_post(div_post),
        .reg_rdata(reg_rdata), .slice_tick(slice_tick), .slice_clk(slice_clk)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (slice_tick) pulses++;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit g, int s, int p, int q);
        logic [31:0] w;
        w = '0;
        w[28] = g;
        w[26:24] = s[2:0];
        w[18:16] = p[2:0];
        w[5:0] = q[5:0];
        return w;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Selected source ticks every other cycle; every other source ticks every cycle.
    task automatic burst(input int sel, input int k);
        for (int i = 0; i < k; i++) begin
            src_tick = '1;
            @(negedge clk);
            src_tick = '1;
            src_tick[sel] = 1'b0;
            @(negedge clk);
        end
        src_tick = '0;
        idle(2);
    endtask

    task automatic run_cfg(input int sel, input int p, input int q);
        int r, k, expn;
        r = (p + 1) * (q + 1);
        k = 4 * r - 1;
        expn = k / r;
        write_word(mk(1'b0, sel, p, q));
        write_word(mk(1'b1, sel, p, q));
        pulses = 0;
        burst(sel, k);
        check(pulses == expn, "R4/R3 pulse count", pulses, expn);
        check(slice_clk == expn[0], "R9 level parity", slice_clk, expn[0]);
    endtask

    initial begin
        idle(3);
        check(reg_rdata == 32'h0, "R1 reset word", reg_rdata, 0);
        check(slice_tick == 1'b0 && slice_clk == 1'b0, "R1 reset outputs", {slice_tick, slice_clk}, 0);
        rst_n = 1'b1;
        idle(1);

        // R2: unassigned bits are ignored
        write_word(32'hFFFF_FFFF);
        check(reg_rdata == 32'h1707_003F, "R2 layout mask", reg_rdata, 32'h1707003F);
        write_word(32'h0);
        check(reg_rdata == 32'h0, "R2 clear", reg_rdata, 0);

        // R6: divider-only write keeps source and gate
        write_word(32'h1500_0000);
        div_wr = 1'b1; div_pre = 3'd2; div_post = 6'd9;
        @(negedge clk);
        div_wr = 1'b0;
        check(reg_rdata == 32'h1502_0009, "R6 divider write", reg_rdata, 32'h15020009);
        reg_wr = 1'b1; reg_wdata = 32'h0300_0004; div_wr = 1'b1; div_pre = 3'd7; div_post = 6'd63;
        @(negedge clk);
        reg_wr = 1'b0; div_wr = 1'b0;
        check(reg_rdata == 32'h0300_0004, "R6 full write priority", reg_rdata, 32'h03000004);

        // R5: pass-through latency and ratio-6 latency
        write_word(mk(1'b1, 0, 0, 0));
        src_tick[0] = 1'b1;
        @(negedge clk);
        src_tick[0] = 1'b0;
        check(slice_tick == 1'b1, "R5 ratio 1 next cycle", slice_tick, 1);
        @(negedge clk);
        check(slice_tick == 1'b0, "R5 single pulse", slice_tick, 0);
        write_word(mk(1'b1, 2, 1, 2));
        for (int i = 0; i < 5; i++) begin
            src_tick[2] = 1'b1; @(negedge clk);
            src_tick[2] = 1'b0;
            check(slice_tick == 1'b0, "R5 early", slice_tick, 0);
            @(negedge clk);
        end
        src_tick[2] = 1'b1; @(negedge clk);
        src_tick[2] = 1'b0;
        check(slice_tick == 1'b1, "R5 sixth tick", slice_tick, 1);
        @(negedge clk);

        // R7: changing a ratio mid-count restarts from zero
        write_word(mk(1'b1, 1, 0, 3));
        burst(1, 2);
        write_word(mk(1'b1, 1, 0, 2));
        pulses = 0;
        burst(1, 2);
        check(pulses == 0, "R7 restart (2 of 3)", pulses, 0);
        burst(1, 1);
        check(pulses == 1, "R7 restart completes", pulses, 1);

        // R8: gate off holds output low
        write_word(mk(1'b0, 0, 0, 0));
        pulses = 0;
        src_tick = '1;
        idle(40);
        src_tick = '0;
        idle(2);
        check(pulses == 0, "R8 gated pulses", pulses, 0);
        check(slice_clk == 1'b0, "R8 gated level", slice_clk, 0);

        // R4/R3/R9 sweep
        for (int p = 0; p < 8; p++) begin
            for (int qi = 0; qi < 5; qi++) begin
                int q;
                q = (qi == 0) ? 0 : (qi == 1) ? 1 : (qi == 2) ? 2 : (qi == 3) ? 7 : 63;
                run_cfg((p * 3 + qi) % 8, p, q);
            end
        end

        // R1: reset during operation
        write_word(mk(1'b1, 4, 0, 0));
        src_tick = '1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        src_tick = '0;
        check(reg_rdata == 32'h0, "R1 mid-run reset word", reg_rdata, 0);
        check(slice_tick == 1'b0 && slice_clk == 1'b0, "R1 mid-run reset outputs", {slice_tick, slice_clk}, 0);
        rst_n = 1'b1;
        idle(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule